// File: doc/BRIEF.md
# Pipelined Half-Precision Multiplier

This block multiplies two binary16 operands and produces a correctly rounded binary16 product with four exception flags. A new pair of operands and a rounding mode may be presented on every clock cycle together with `in_valid`. The packed result and its flags appear exactly three cycles later with `out_valid`. Operations keep their order and never stall.

The datapath has three register stages. The UNPACK stage sorts both operands into zero, infinity, quiet NaN, signalling NaN, subnormal or normal. It shifts a subnormal operand left until its leading one reaches the hidden position, and it adds the unbiased exponents. The ALIGN stage forms the 11x11 significand product and applies the single normalising shift. When the exponent is below the normal range, it shifts the significand right into subnormal form and folds the lost bits into sticky. The ROUND stage applies the selected mode from the guard, round and sticky bits. It renormalises on a carry out, detects overflow and packs the word. Results for special operands are decided in UNPACK and bypass the arithmetic. Each stage carries its own valid bit, and these bits are the only state that reset clears.

Top module: `fp16_mul_pipe`

## Requirements
- R1: A product enters when `in_valid` is high at a rising edge. Its result is presented with `out_valid` high after the third rising edge that follows. One operation is accepted per cycle, and `out_valid` is low during and right after reset.
- R2: For every result that is not a NaN, the sign bit is the XOR of the two operand sign bits (bit 15 of each word).
- R3: For normal operands, the exponent field is the sum of the operand exponents minus 15, plus one when the significand product is 2 or more. When rounding carries out of the significand, the result is renormalised and the exponent is incremented.
- R4: `rnd_mode` selects rounding: 0 nearest with ties to even, 1 toward zero, 2 toward negative infinity, 3 toward positive infinity, 4 nearest with ties away from zero. Codes 5 to 7 behave as code 0.
- R5: A subnormal operand (exponent field 0, nonzero fraction) is used at its exact value, with a hidden bit of 0.
- R6: A product whose exponent, before rounding, lies below the smallest normal exponent is delivered as a correctly rounded subnormal or zero. `flag_underflow` is raised only when such a tiny product is also inexact.
- R7: An overflowing product raises `flag_overflow` and `flag_inexact`. It returns infinity (0x7C00 with sign) in modes 0 and 4, and the largest finite magnitude (0x7BFF with sign) in mode 1. Mode 3 gives infinity only for a positive result and mode 2 only for a negative one.
- R8: Zero times infinity, or any signalling NaN operand (fraction MSB 0), returns 0x7E00 and raises only `flag_invalid`.
- R9: A quiet NaN operand (fraction MSB 1), with no signalling NaN present, returns 0x7E00 with no flag raised.
- R10: Infinity times a nonzero non-NaN value returns infinity, and zero times a finite value returns zero. In both cases the sign is the XOR of the operand signs and no flag is raised.
- R11: `flag_inexact` is raised exactly when the rounded result differs from the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are present this cycle |
| op_a | input | 16 | First binary16 operand |
| op_b | input | 16 | Second binary16 operand |
| rnd_mode | input | 3 | Rounding mode code (see R4) |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 16 | Packed binary16 product |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Rounded result exceeded the finite range |
| flag_underflow | output | 1 | Tiny and inexact result |
| flag_inexact | output | 1 | Result differs from the exact product |

## Verification
The assertions take for granted that `in_valid` is held low while reset is asserted. They also assume that the operand words hold known values on every cycle in which `in_valid` is high, because the sign and latency properties look three cycles back at those inputs. The stimulus keeps `in_valid` low throughout reset and changes inputs only on falling edges. It always drives fully defined operand words and mode codes, including codes 5 to 7. Random operand words cover every exponent field value, so NaNs, infinities and subnormals mix freely with normal values.

// File: rtl/fp16_mul_pkg.sv
package fp16_mul_pkg;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 10;
    localparam int MANT_W = FRAC_W + 1;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int PROD_W = 2 * MANT_W;
    localparam int SIG_W  = PROD_W + 2;
    localparam int ESUM_W = EXP_W + 3;
    localparam int EB_W   = EXP_W + 2;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_AWAY = 3'd4
    } rmode_e;
endpackage

// File: rtl/fp16_unpack.sv
module fp16_unpack
    import fp16_mul_pkg::*;
(
    input  logic [WORD_W-1:0]        opnd,
    output logic [MANT_W-1:0]        mant,
    output logic signed [ESUM_W-1:0] uexp,
    output logic                     is_zero,
    output logic                     is_inf,
    output logic                     is_nan,
    output logic                     is_snan
);
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;
    logic [MANT_W-1:0] fx;
    logic              found;
    int                lz;

    assign ef = opnd[WORD_W-2:FRAC_W];
    assign ff = opnd[FRAC_W-1:0];
    assign fx = {1'b0, ff};

    assign is_zero = ~|ef & ~|ff;
    assign is_inf  = &ef & ~|ff;
    assign is_nan  = &ef & |ff;
    assign is_snan = is_nan & ~ff[FRAC_W-1];

    // leading-zero count over the hidden-bit-extended fraction
    always_comb begin
        lz    = 0;
        found = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (fx[i]) found = 1'b1;
                else       lz = lz + 1;
            end
        end
    end

    always_comb begin
        if (~|ef) begin
            mant = fx << lz;
            uexp = ESUM_W'(1 - BIAS - lz);
        end else begin
            mant = {1'b1, ff};
            uexp = ESUM_W'(int'(ef) - BIAS);
        end
    end
endmodule

// File: rtl/fp16_prod_align.sv
module fp16_prod_align
    import fp16_mul_pkg::*;
(
    input  logic [MANT_W-1:0]        ma,
    input  logic [MANT_W-1:0]        mb,
    input  logic signed [ESUM_W-1:0] esum,
    output logic [MANT_W-1:0]        mant,
    output logic                     guard,
    output logic                     rnd,
    output logic                     sticky,
    output logic [EB_W-1:0]          eb,
    output logic                     tiny
);
    logic [PROD_W-1:0] prod;
    logic [SIG_W-1:0]  sig, shd, mask;
    logic              lost;
    int                ebi, dsh;

    assign prod = PROD_W'(ma) * PROD_W'(mb);
    // one-position normalisation: product lies in [1,4)
    assign sig  = prod[PROD_W-1] ? {prod, 2'b00} : {prod[PROD_W-2:0], 3'b000};

    always_comb begin
        ebi = int'(esum) + int'(prod[PROD_W-1]) + BIAS;
        if (ebi < 1) begin
            dsh  = 1 - ebi;
            tiny = 1'b1;
            eb   = EB_W'(1);
        end else begin
            dsh  = 0;
            tiny = 1'b0;
            eb   = EB_W'(ebi);
        end
    end

    assign shd    = sig >> dsh;
    assign mask   = ~({SIG_W{1'b1}} << dsh);
    assign lost   = |(sig & mask);
    assign mant   = shd[SIG_W-1 -: MANT_W];
    assign guard  = shd[SIG_W-MANT_W-1];
    assign rnd    = shd[SIG_W-MANT_W-2];
    assign sticky = |shd[SIG_W-MANT_W-3:0] | lost;
endmodule

// File: rtl/fp16_round.sv
module fp16_round
    import fp16_mul_pkg::*;
(
    input  logic              sgn,
    input  logic [MANT_W-1:0] mant,
    input  logic              guard,
    input  logic              rnd,
    input  logic              sticky,
    input  logic [EB_W-1:0]   eb,
    input  logic              tiny,
    input  logic [2:0]        rm,
    output logic [WORD_W-1:0] res,
    output logic              ovf,
    output logic              unf,
    output logic              inx
);
    logic              lost_any, inc, to_inf;
    logic [MANT_W:0]   msum;
    logic [MANT_W-1:0] mfin;
    logic [EB_W-1:0]   efin;

    assign lost_any = guard | rnd | sticky;

    always_comb begin
        case (rm)
            RM_ZERO:      begin inc = 1'b0;               to_inf = 1'b0; end
            RM_DOWN:      begin inc = sgn & lost_any;     to_inf = sgn;  end
            RM_UP:        begin inc = ~sgn & lost_any;    to_inf = ~sgn; end
            RM_NEAR_AWAY: begin inc = guard;              to_inf = 1'b1; end
            default:      begin inc = guard & (rnd | sticky | mant[0]); to_inf = 1'b1; end
        endcase
    end

    assign msum = {1'b0, mant} + (MANT_W+1)'(inc);

    always_comb begin
        if (msum[MANT_W]) begin
            mfin = {1'b1, {FRAC_W{1'b0}}};
            efin = eb + 1'b1;
        end else begin
            mfin = msum[MANT_W-1:0];
            efin = eb;
        end
    end

    assign ovf = mfin[MANT_W-1] && (efin >= EB_W'(EXP_MAX));
    assign inx = lost_any | ovf;
    assign unf = tiny & lost_any;

    always_comb begin
        if (ovf)
            res = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        else
            res = {sgn, mfin[MANT_W-1] ? efin[EXP_W-1:0] : {EXP_W{1'b0}},
                   mfin[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fp16_mul_pipe.sv
module fp16_mul_pipe
    import fp16_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       op_a,
    input  logic [15:0]       op_b,
    input  logic [2:0]        rnd_mode,
    output logic              out_valid,
    output logic [15:0]       result,
    output logic              flag_invalid,
    output logic              flag_overflow,
    output logic              flag_underflow,
    output logic              flag_inexact
);
    // UNPACK stage
    logic [MANT_W-1:0]        ma_c, mb_c;
    logic signed [ESUM_W-1:0] ea_c, eb_c;
    logic za, zb, ia, ib, na, nb, sa, sb;
    logic                     sgn_c, spec_c, inv_c;
    logic [WORD_W-1:0]        spec_res_c;

    fp16_unpack u_unpack_a (.opnd(op_a), .mant(ma_c), .uexp(ea_c),
        .is_zero(za), .is_inf(ia), .is_nan(na), .is_snan(sa));
    fp16_unpack u_unpack_b (.opnd(op_b), .mant(mb_c), .uexp(eb_c),
        .is_zero(zb), .is_inf(ib), .is_nan(nb), .is_snan(sb));

    assign sgn_c  = op_a[WORD_W-1] ^ op_b[WORD_W-1];
    assign spec_c = na | nb | ia | ib | za | zb;
    assign inv_c  = sa | sb | (za & ib) | (zb & ia);

    always_comb begin
        if (na | nb | (za & ib) | (zb & ia))
            spec_res_c = QNAN_WORD;
        else if (ia | ib)
            spec_res_c = {sgn_c, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            spec_res_c = {sgn_c, {(WORD_W-1){1'b0}}};
    end

    logic                     v1, sgn1, spec1, inv1;
    logic [MANT_W-1:0]        ma1, mb1;
    logic signed [ESUM_W-1:0] esum1;
    logic [2:0]               rm1;
    logic [WORD_W-1:0]        sres1;

    always_ff @(posedge clk) begin
        if (!rst_n) v1 <= 1'b0;
        else        v1 <= in_valid;
        sgn1  <= sgn_c;
        spec1 <= spec_c;
        inv1  <= inv_c;
        sres1 <= spec_res_c;
        ma1   <= ma_c;
        mb1   <= mb_c;
        esum1 <= ea_c + eb_c;
        rm1   <= rnd_mode;
    end

    // ALIGN stage
    logic [MANT_W-1:0] mant_c;
    logic              g_c, r_c, s_c, tiny_c;
    logic [EB_W-1:0]   ebf_c;

    fp16_prod_align u_align (.ma(ma1), .mb(mb1), .esum(esum1), .mant(mant_c),
        .guard(g_c), .rnd(r_c), .sticky(s_c), .eb(ebf_c), .tiny(tiny_c));

    logic              v2, sgn2, spec2, inv2, g2, r2, s2, tiny2;
    logic [MANT_W-1:0] mant2;
    logic [EB_W-1:0]   ebf2;
    logic [2:0]        rm2;
    logic [WORD_W-1:0] sres2;

    always_ff @(posedge clk) begin
        if (!rst_n) v2 <= 1'b0;
        else        v2 <= v1;
        sgn2  <= sgn1;
        spec2 <= spec1;
        inv2  <= inv1;
        sres2 <= sres1;
        mant2 <= mant_c;
        g2    <= g_c;
        r2    <= r_c;
        s2    <= s_c;
        ebf2  <= ebf_c;
        tiny2 <= tiny_c;
        rm2   <= rm1;
    end

    // ROUND stage
    logic [WORD_W-1:0] rres_c;
    logic              ovf_c, unf_c, inx_c;

    fp16_round u_round (.sgn(sgn2), .mant(mant2), .guard(g2), .rnd(r2),
        .sticky(s2), .eb(ebf2), .tiny(tiny2), .rm(rm2), .res(rres_c),
        .ovf(ovf_c), .unf(unf_c), .inx(inx_c));

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v2;
        if (spec2) begin
            result         <= sres2;
            flag_invalid   <= inv2;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            flag_inexact   <= 1'b0;
        end else begin
            result         <= rres_c;
            flag_invalid   <= 1'b0;
            flag_overflow  <= ovf_c;
            flag_underflow <= unf_c;
            flag_inexact   <= inx_c;
        end
    end
endmodule

// File: rtl/fp16_mul_pipe_chk.sv
module fp16_mul_pipe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        out_valid,
    input logic [15:0] result,
    input logic        flag_invalid,
    input logic        flag_overflow,
    input logic        flag_underflow,
    input logic        flag_inexact
);
    logic res_is_nan;
    assign res_is_nan = (&result[14:10]) && (|result[9:0]);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3)); // R1

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_is_nan) |->
        (result[15] == ($past(op_a[15], 3) ^ $past(op_b[15], 3)))); // R2

    AST_UNDERFLOW_TINY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_underflow) |->
        (flag_inexact && (result[14:10] <= 5'd1))); // R6

    AST_OVERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_overflow) |-> (flag_inexact && !flag_underflow)); // R7

    AST_INVALID_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |->
        (result == 16'h7E00 && !flag_overflow && !flag_underflow && !flag_inexact)); // R8

    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_is_nan) |->
        (result == 16'h7E00 && !flag_overflow && !flag_inexact)); // R9
endmodule

bind fp16_mul_pipe fp16_mul_pipe_chk u_chk (.*);

// File: tb/fp16_mul_pipe_test.sv
module fp16_mul_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [2:0]  rnd_mode = '0;
    logic        out_valid, flag_invalid, flag_overflow, flag_underflow, flag_inexact;
    logic [15:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    fp16_mul_pipe uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode), .out_valid(out_valid),
        .result(result), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact));

    // exact-value reference: product = P * 2^ep, rounded to a quantum of 2^q
    function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [2:0] rm);
        logic sg, nan_a, nan_b, sn_a, sn_b, inf_a, inf_b, z_a, z_b;
        logic inexact, inc, tiny, ovf, to_inf;
        int xa, xb, fa, fb, ea, eb, ep, k, q, s, field, elead;
        longint ma, mb, p, mq, rem, half;
        sg = a[15] ^ b[15];
        xa = int'(a[14:10]); fa = int'(a[9:0]);
        xb = int'(b[14:10]); fb = int'(b[9:0]);
        nan_a = (xa == 31) && (fa != 0); nan_b = (xb == 31) && (fb != 0);
        sn_a = nan_a && (fa < 512);      sn_b = nan_b && (fb < 512);
        inf_a = (xa == 31) && (fa == 0); inf_b = (xb == 31) && (fb == 0);
        z_a = (xa == 0) && (fa == 0);    z_b = (xb == 0) && (fb == 0);
        if (nan_a || nan_b) return {16'h7E00, sn_a || sn_b, 3'b000};
        if ((inf_a && z_b) || (inf_b && z_a)) return {16'h7E00, 4'b1000};
        if (inf_a || inf_b) return {sg, 15'h7C00, 4'b0000};
        if (z_a || z_b) return {sg, 15'h0000, 4'b0000};
        ma = (xa == 0) ? longint'(fa) : longint'(fa + 1024);
        mb = (xb == 0) ? longint'(fb) : longint'(fb + 1024);
        ea = (xa == 0) ? -24 : xa - 25;
        eb = (xb == 0) ? -24 : xb - 25;
        p = ma * mb; ep = ea + eb;
        k = 0;
        for (int i = 0; i < 40; i++) if ((p >> i) != 0) k = i;
        elead = k + ep;
        q = elead - 10;
        if (q < -24) q = -24;
        s = q - ep;
        if (s <= 0) begin
            mq = p << (-s); rem = 0; half = 1;
        end else begin
            if (s > 40) s = 40;
            mq = p >> s; rem = p - (mq << s); half = longint'(1) << (s - 1);
        end
        inexact = (rem != 0);
        case (rm)
            3'd1: inc = 1'b0;
            3'd2: inc = sg && inexact;
            3'd3: inc = !sg && inexact;
            3'd4: inc = inexact && (rem >= half);
            default: inc = (rem > half) || (inexact && rem == half && mq[0]);
        endcase
        mq = mq + longint'(inc);
        if (mq == 2048) begin mq = 1024; q = q + 1; end
        field = (mq >= 1024) ? q + 25 : 0;
        tiny = elead < -14;
        ovf = field >= 31;
        if (ovf) begin
            case (rm)
                3'd1: to_inf = 1'b0;
                3'd2: to_inf = sg;
                3'd3: to_inf = !sg;
                default: to_inf = 1'b1;
            endcase
            return {(to_inf ? {sg, 15'h7C00} : {sg, 15'h7BFF}), 4'b0101};
        end
        return {sg, 5'(field), mq[9:0], 1'b0, 1'b0, tiny && inexact, inexact};
    endfunction

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] rm, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = rm; in_valid = 1'b1;
        exp_q.push_back(model(a, b, rm));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops the oldest expectation on each valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [19:0] got, exp_v;
            string t;
            got = {result, flag_invalid, flag_overflow, flag_underflow, flag_inexact};
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected result got=%h expected=none", got);
            end else begin
                exp_v = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== exp_v) begin
                    n_bad++;
                    $display("FAIL %s: got=%h expected=%h", t, got, exp_v);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired got=hang expected=completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid in reset got=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid after reset got=%b expected=0", out_valid);
        end
        // R3 normal products, exponent sum and normalisation, back to back
        drive(16'h3E00, 16'h3E00, 3'd0, "R3");
        drive(16'h4000, 16'h4200, 3'd0, "R3");
        drive(16'h3FFF, 16'h3FFF, 3'd0, "R3");
        drive(16'h3C01, 16'h3FFF, 3'd3, "R3");
        idle(2);
        // R2 sign
        drive(16'hBE00, 16'h4200, 3'd0, "R2");
        drive(16'hBC00, 16'hBC00, 3'd0, "R2");
        // R4 modes, including ties and codes 5..7
        for (int m = 0; m < 8; m++) begin
            drive(16'h3C01, 16'h3C01, 3'(m), "R4");
            drive(16'hBC01, 16'h3C01, 3'(m), "R4");
            drive(16'h3C01, 16'h3E00, 3'(m), "R4");
            drive(16'h3C03, 16'hBE00, 3'(m), "R4");
        end
        // R5 subnormal operands
        drive(16'h0001, 16'h4000, 3'd0, "R5");
        drive(16'h0200, 16'h4400, 3'd0, "R5");
        drive(16'h03FF, 16'h6400, 3'd0, "R5");
        // R6 subnormal results and underflow
        drive(16'h0400, 16'h3800, 3'd0, "R6");
        drive(16'h0401, 16'h3800, 3'd0, "R6");
        drive(16'h0001, 16'h3800, 3'd0, "R6");
        drive(16'h0001, 16'h3800, 3'd3, "R6");
        drive(16'h0001, 16'h0001, 3'd3, "R6");
        drive(16'h03FF, 16'h3C01, 3'd3, "R6");
        // R7 overflow in each mode, both signs
        for (int m = 0; m < 5; m++) begin
            drive(16'h7BFF, 16'h4000, 3'(m), "R7");
            drive(16'hFBFF, 16'h4000, 3'(m), "R7");
        end
        // R8 invalid
        drive(16'h0000, 16'h7C00, 3'd0, "R8");
        drive(16'hFC00, 16'h8000, 3'd0, "R8");
        drive(16'h7D00, 16'h3C00, 3'd0, "R8");
        drive(16'h7E00, 16'hFC01, 3'd0, "R8");
        // R9 quiet NaN
        drive(16'h7E00, 16'h3C00, 3'd0, "R9");
        drive(16'h3C00, 16'hFE01, 3'd2, "R9");
        // R10 infinities and zeros
        drive(16'h7C00, 16'hC000, 3'd0, "R10");
        drive(16'h7C00, 16'h0001, 3'd1, "R10");
        drive(16'h8000, 16'h4000, 3'd0, "R10");
        drive(16'h0000, 16'h0000, 3'd3, "R10");
        // R11 exact vs inexact
        drive(16'h3E00, 16'h4000, 3'd0, "R11");
        drive(16'h3C01, 16'h3C01, 3'd1, "R11");
        idle(3);
        // random mix across every exponent field and mode code
        for (int i = 0; i < 3000; i++) begin
            drive(16'($urandom), 16'($urandom), 3'($urandom), "R4");
            if ((i % 7) == 0) idle(1);
        end
        idle(6);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: results outstanding got=%0d expected=0", exp_q.size());
        end
        summary();
    end
endmodule